// File: doc/BRIEF.md
# Programmable Video Timing Pattern Generator

This block builds a full video raster from timing values that are supplied at run time. At pixel-clock rate it drives a data-enable, a horizontal sync and a vertical sync. It also drives a synthetic colour-bar picture and the coordinates of the current active pixel. It serves as a built-in self-test source that stands in for received video, so the downstream display path can be exercised without a live input.

Every timing value arrives as a split field: a low byte plus a narrow high part. Sync pulses have a programmable polarity. The generator latches its timing set only at frame boundaries. It restarts from the top-left corner of the raster each time it is enabled.

Top module: `vtg_pattern_gen`

## Requirements
- R1: After reset, and from the first clock edge at which `enable` is sampled low, `de`, `hs` and `vs` sit at their inactive levels and `rgb`, `x_pos` and `y_pos` are zero. The inactive level of each is the value of its polarity input `de_low`, `hs_low` or `vs_low`.
- R2: At the first edge where `enable` is sampled high, the generator starts at line 0, pixel 0. It starts there again after every disable and re-enable.
- R3: Each line runs front porch, then horizontal sync, then back porch, then the active pixels, with lengths `h_front`, sync width, `h_back` and active width. Sync and data-enable are never active together.
- R4: Each frame runs the same order in whole lines: `v_front`, vertical sync width, `v_back`, then the active lines. `vs` holds its level for entire lines.
- R5: The active width and height are `{*_act_hi[3:0], *_act_lo[7:0]}`. The sync widths are `{*_sync_hi[1:0], *_sync_lo[7:0]}`.
- R6: A sync width of zero behaves as one, so every line and frame carries a sync pulse. A porch of zero takes no cycles.
- R7: An active width or height of zero behaves as one.
- R8: Timing inputs are captured only at enable and at the first pixel of each new frame. Changes made mid-frame take effect from the next frame.
- R9: The polarity inputs apply immediately. Output equals the active state XOR its polarity input, with 1 meaning the signal is active-low.
- R10: While data-enable is active, `x_pos` and `y_pos` give the column and row within the active area, counting from 0. Outside it both are 0.
- R11: The picture is eight vertical bars of width max(1, width/8) with integer division. The bar index is min(7, x / bar width). Red (`rgb[23:16]`), green (`rgb[15:8]`) and blue (`rgb[7:0]`) are 8'hFF when index bit 2, 1 or 0 respectively is 0, and 8'h00 otherwise. Outside the active area `rgb` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the generator; low forces idle |
| h_act_lo | input | 8 | Active width, low byte |
| h_act_hi | input | 4 | Active width, high bits |
| v_act_lo | input | 8 | Active height, low byte |
| v_act_hi | input | 4 | Active height, high bits |
| h_sync_lo | input | 8 | Horizontal sync width, low byte |
| h_sync_hi | input | 2 | Horizontal sync width, high bits |
| v_sync_lo | input | 8 | Vertical sync width in lines, low byte |
| v_sync_hi | input | 2 | Vertical sync width, high bits |
| h_front | input | 8 | Horizontal front porch, pixels |
| h_back | input | 8 | Horizontal back porch, pixels |
| v_front | input | 8 | Vertical front porch, lines |
| v_back | input | 8 | Vertical back porch, lines |
| de_low | input | 1 | Data-enable active-low select |
| hs_low | input | 1 | Horizontal sync active-low select |
| vs_low | input | 1 | Vertical sync active-low select |
| de | output | 1 | Data enable |
| hs | output | 1 | Horizontal sync |
| vs | output | 1 | Vertical sync |
| rgb | output | 24 | Pattern pixel, red in the upper byte |
| x_pos | output | 12 | Active column |
| y_pos | output | 12 | Active row |

## Verification
The assertions watch every cycle for the properties that hold at any instant. Outputs go idle one edge after `enable` falls. Coordinates and colour are zero outside the active area. Sync and data-enable never overlap. Within a line the column steps by one and the row holds. Bar channels are always fully on or fully off.

The placement of each phase, the minimum-one widths, the high-field assembly, the frame-boundary capture of new values, the restart point and the bar widths with their saturation all depend on the programmed values. The directed scenarios show these by running the design alongside a cycle-level reference built from the requirements.

// File: rtl/vtg_pkg.sv
// Shared widths and the per-axis timing record for the pattern generator.
// Assumes timing fields are at most one byte wide in their low part.
package vtg_pkg;
    localparam int BYTE_W    = 8;
    localparam int ACT_W     = 12;
    localparam int SW_W      = 10;
    localparam int PORCH_W   = 8;
    localparam int ACT_HI_W  = ACT_W - BYTE_W;
    localparam int SW_HI_W   = SW_W - BYTE_W;
    localparam int POS_W     = ACT_W + 2;
    localparam int COLOR_W   = 8;
    localparam int BAR_IDX_W = 3;
    localparam int N_CHAN    = 3;

    typedef struct packed {
        logic [ACT_W-1:0]   act;
        logic [SW_W-1:0]    sw;
        logic [PORCH_W-1:0] fp;
        logic [PORCH_W-1:0] bp;
    } axis_cfg_t;
endpackage

// File: rtl/vtg_axis_timer.sv
// One raster axis: a position counter over front porch, sync, back porch and
// active phases. Assumes cfg stays stable while step may be asserted; zero
// sync and active lengths are raised to one.
module vtg_axis_timer
    import vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic             in_sync,
    output logic             in_act,
    output logic             last,
    output logic [ACT_W-1:0] act_ofs
);
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] sw_e, act_e, sync_end, act_start, total_last;

    // Phase boundaries derived from the captured configuration.
    always_comb begin
        sw_e       = (cfg.sw == '0)  ? POS_W'(1) : POS_W'(cfg.sw);
        act_e      = (cfg.act == '0) ? POS_W'(1) : POS_W'(cfg.act);
        sync_end   = POS_W'(cfg.fp) + sw_e;
        act_start  = sync_end + POS_W'(cfg.bp);
        total_last = act_start + act_e - POS_W'(1);
    end

    // Phase decode of the current position.
    always_comb begin
        in_sync = (pos >= POS_W'(cfg.fp)) && (pos < sync_end);
        in_act  = (pos >= act_start);
        last    = (pos == total_last);
        act_ofs = in_act ? ACT_W'(pos - act_start) : '0;
    end

    // Position counter: cleared while idle, wraps after the last active unit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos <= '0;
        end else if (step) begin
            pos <= last ? '0 : pos + POS_W'(1);
        end
    end
endmodule

// File: rtl/vtg_bar_pattern.sv
// Eight-bar colour pattern. A per-line bar counter advances every bar width
// pixels and saturates on the last bar. Assumes active drops for at least one
// cycle between lines, which the sync phase guarantees.
module vtg_bar_pattern
    import vtg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      active,
    input  logic [ACT_W-1:0]          act_len,
    output logic [N_CHAN*COLOR_W-1:0] rgb
);
    localparam int BW_W = ACT_W - BAR_IDX_W;

    logic [BW_W-1:0]      bar_w, sub;
    logic [BAR_IDX_W-1:0] idx;

    // Bar width is one eighth of the active width, never below one.
    always_comb begin
        bar_w = (act_len[ACT_W-1:BAR_IDX_W] == '0) ? BW_W'(1)
                                                   : act_len[ACT_W-1:BAR_IDX_W];
    end

    // Bar index tracking along the active part of a line.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sub <= '0;
            idx <= '0;
        end else if (sub == bar_w - BW_W'(1)) begin
            sub <= '0;
            if (idx != '1) idx <= idx + BAR_IDX_W'(1);
        end else begin
            sub <= sub + BW_W'(1);
        end
    end

    // One channel per index bit; a cleared bit lights the channel.
    for (genvar k = 0; k < N_CHAN; k++) begin : g_chan
        assign rgb[k*COLOR_W +: COLOR_W] = (active && !idx[k]) ? '1 : '0;
    end
endmodule

// File: rtl/vtg_pattern_gen.sv
// Programmable timing and test-pattern generator. It captures split timing
// fields at enable and at each frame start, runs horizontal and vertical axis
// timers, and drives polarity-adjusted syncs, data enable, colour bars and
// active coordinates. Assumes the polarity inputs may change at any time.
module vtg_pattern_gen
    import vtg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [BYTE_W-1:0]         h_act_lo,
    input  logic [ACT_HI_W-1:0]       h_act_hi,
    input  logic [BYTE_W-1:0]         v_act_lo,
    input  logic [ACT_HI_W-1:0]       v_act_hi,
    input  logic [BYTE_W-1:0]         h_sync_lo,
    input  logic [SW_HI_W-1:0]        h_sync_hi,
    input  logic [BYTE_W-1:0]         v_sync_lo,
    input  logic [SW_HI_W-1:0]        v_sync_hi,
    input  logic [PORCH_W-1:0]        h_front,
    input  logic [PORCH_W-1:0]        h_back,
    input  logic [PORCH_W-1:0]        v_front,
    input  logic [PORCH_W-1:0]        v_back,
    input  logic                      de_low,
    input  logic                      hs_low,
    input  logic                      vs_low,
    output logic                      de,
    output logic                      hs,
    output logic                      vs,
    output logic [N_CHAN*COLOR_W-1:0] rgb,
    output logic [ACT_W-1:0]          x_pos,
    output logic [ACT_W-1:0]          y_pos
);
    logic             run, load, frame_end, pix_act;
    axis_cfg_t        h_cfg, v_cfg;
    logic             h_sync_i, h_act_i, h_last;
    logic             v_sync_i, v_act_i, v_last;
    logic [ACT_W-1:0] h_ofs, v_ofs;

    assign frame_end = run && h_last && v_last;
    assign load      = enable && (!run || frame_end);

    // Run flag follows enable one edge later; its rise is the restart point.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= enable;
    end

    // Timing capture from the split inputs, only at frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cfg <= '0;
            v_cfg <= '0;
        end else if (load) begin
            h_cfg.act <= {h_act_hi, h_act_lo};
            h_cfg.sw  <= {h_sync_hi, h_sync_lo};
            h_cfg.fp  <= h_front;
            h_cfg.bp  <= h_back;
            v_cfg.act <= {v_act_hi, v_act_lo};
            v_cfg.sw  <= {v_sync_hi, v_sync_lo};
            v_cfg.fp  <= v_front;
            v_cfg.bp  <= v_back;
        end
    end

    vtg_axis_timer u_h_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run),
        .step    (run),
        .cfg     (h_cfg),
        .in_sync (h_sync_i),
        .in_act  (h_act_i),
        .last    (h_last),
        .act_ofs (h_ofs)
    );

    vtg_axis_timer u_v_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run),
        .step    (run && h_last),
        .cfg     (v_cfg),
        .in_sync (v_sync_i),
        .in_act  (v_act_i),
        .last    (v_last),
        .act_ofs (v_ofs)
    );

    assign pix_act = run && h_act_i && v_act_i;

    vtg_bar_pattern u_bars (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (pix_act),
        .act_len (h_cfg.act),
        .rgb     (rgb)
    );

    // Output stage: live polarity and blanked coordinates.
    always_comb begin
        de    = pix_act ^ de_low;
        hs    = (run && h_sync_i) ^ hs_low;
        vs    = (run && v_sync_i) ^ vs_low;
        x_pos = pix_act ? h_ofs : '0;
        y_pos = pix_act ? v_ofs : '0;
    end
endmodule

// File: rtl/vtg_checker.sv
// Cycle properties of the pattern generator, observed at its ports.
module vtg_checker
    import vtg_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      enable,
    input logic                      de_low,
    input logic                      hs_low,
    input logic                      vs_low,
    input logic                      de,
    input logic                      hs,
    input logic                      vs,
    input logic [N_CHAN*COLOR_W-1:0] rgb,
    input logic [ACT_W-1:0]          x_pos,
    input logic [ACT_W-1:0]          y_pos
);
    logic de_on, hs_on, vs_on;
    assign de_on = de ^ de_low;
    assign hs_on = hs ^ hs_low;
    assign vs_on = vs ^ vs_low;

    p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!de_on && !hs_on && !vs_on && rgb == '0 &&
                            x_pos == '0 && y_pos == '0));

    p_sync_de_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |-> !de_on);

    p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (de_on && $past(de_on)) |-> (y_pos == $past(y_pos)));

    p_blank_coords_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !de_on |-> (x_pos == '0 && y_pos == '0 && rgb == '0));

    p_col_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (de_on && $past(de_on)) |-> (x_pos == ACT_W'($past(x_pos) + 1'b1)));

    p_bar_levels_r11: assert property (@(posedge clk) disable iff (!rst_n)
        de_on |-> ((rgb[0 +: COLOR_W] == '0 || rgb[0 +: COLOR_W] == '1) &&
                   (rgb[COLOR_W +: COLOR_W] == '0 || rgb[COLOR_W +: COLOR_W] == '1) &&
                   (rgb[2*COLOR_W +: COLOR_W] == '0 || rgb[2*COLOR_W +: COLOR_W] == '1)));
endmodule

bind vtg_pattern_gen vtg_checker u_vtg_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .de_low (de_low),
    .hs_low (hs_low),
    .vs_low (vs_low),
    .de     (de),
    .hs     (hs),
    .vs     (vs),
    .rgb    (rgb),
    .x_pos  (x_pos),
    .y_pos  (y_pos)
);

// File: tb/vtg_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module vtg_pattern_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  h_act_lo = '0, v_act_lo = '0, h_sync_lo = '0, v_sync_lo = '0;
    logic [3:0]  h_act_hi = '0, v_act_hi = '0;
    logic [1:0]  h_sync_hi = '0, v_sync_hi = '0;
    logic [7:0]  h_front = '0, h_back = '0, v_front = '0, v_back = '0;
    logic        de_low = 1'b0, hs_low = 1'b1, vs_low = 1'b1;
    logic        de, hs, vs;
    logic [23:0] rgb;
    logic [11:0] x_pos, y_pos;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    vtg_pattern_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .h_act_lo(h_act_lo), .h_act_hi(h_act_hi),
        .v_act_lo(v_act_lo), .v_act_hi(v_act_hi),
        .h_sync_lo(h_sync_lo), .h_sync_hi(h_sync_hi),
        .v_sync_lo(v_sync_lo), .v_sync_hi(v_sync_hi),
        .h_front(h_front), .h_back(h_back), .v_front(v_front), .v_back(v_back),
        .de_low(de_low), .hs_low(hs_low), .vs_low(vs_low),
        .de(de), .hs(hs), .vs(vs), .rgb(rgb), .x_pos(x_pos), .y_pos(y_pos)
    );

    // Reference model state built from the requirements.
    int m_run = 0, hp = 0, vp = 0;
    int s_hact, s_vact, s_hsw, s_vsw, s_hfp, s_hbp, s_vfp, s_vbp;

    function automatic int at_least1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int htot();
        return s_hfp + at_least1(s_hsw) + s_hbp + at_least1(s_hact);
    endfunction

    function automatic int vtot();
        return s_vfp + at_least1(s_vsw) + s_vbp + at_least1(s_vact);
    endfunction

    task automatic m_load();
        s_hact = {h_act_hi, h_act_lo};  s_vact = {v_act_hi, v_act_lo};
        s_hsw  = {h_sync_hi, h_sync_lo}; s_vsw = {v_sync_hi, v_sync_lo};
        s_hfp = h_front; s_hbp = h_back; s_vfp = v_front; s_vbp = v_back;
    endtask

    // Model advance on each rising edge; inputs only change on falling edges.
    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            m_run = 0; hp = 0; vp = 0;
        end else if (m_run == 0) begin
            m_load(); m_run = 1; hp = 0; vp = 0;
        end else if (hp == htot() - 1) begin
            hp = 0;
            if (vp == vtot() - 1) begin vp = 0; m_load(); end
            else vp = vp + 1;
        end else begin
            hp = hp + 1;
        end
    end

    task automatic cmp(input string tag, input string fld, input int act, input int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h (hp=%0d vp=%0d)", tag, fld, act, exp, hp, vp);
        end
    endtask

    // One check: every output against the reference for this cycle.
    task automatic check_cycle(input string tag);
        int hsync_a, de_a, vsync_a, ex, ey, bw, idx, e_rgb;
        int hab, vab;
        hab = s_hfp + at_least1(s_hsw) + s_hbp;
        vab = s_vfp + at_least1(s_vsw) + s_vbp;
        hsync_a = (m_run != 0) && hp >= s_hfp && hp < s_hfp + at_least1(s_hsw);
        vsync_a = (m_run != 0) && vp >= s_vfp && vp < s_vfp + at_least1(s_vsw);
        de_a    = (m_run != 0) && hp >= hab && vp >= vab;
        ex = de_a ? hp - hab : 0;
        ey = de_a ? vp - vab : 0;
        bw = at_least1(s_hact / 8);
        idx = ex / bw; if (idx > 7) idx = 7;
        e_rgb = 0;
        if (de_a) begin
            if (!idx[2]) e_rgb |= 24'hFF0000;
            if (!idx[1]) e_rgb |= 24'h00FF00;
            if (!idx[0]) e_rgb |= 24'h0000FF;
        end
        n_checks++;
        cmp(tag, "de R3", int'(de),  de_a ^ int'(de_low));
        cmp(tag, "hs R3", int'(hs),  hsync_a ^ int'(hs_low));
        cmp(tag, "vs R4", int'(vs),  vsync_a ^ int'(vs_low));
        cmp(tag, "x R10", int'(x_pos), ex);
        cmp(tag, "y R10", int'(y_pos), ey);
        cmp(tag, "rgb R11", int'(rgb), e_rgb);
    endtask

    task automatic run_cycles(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_cycle(tag);
        end
    endtask

    task automatic set_cfg(input int hact, input int vact, input int hsw, input int vsw,
                           input int hfp, input int hbp, input int vfp, input int vbp);
        h_act_lo = hact[7:0]; h_act_hi = hact[11:8];
        v_act_lo = vact[7:0]; v_act_hi = vact[11:8];
        h_sync_lo = hsw[7:0]; h_sync_hi = hsw[9:8];
        v_sync_lo = vsw[7:0]; v_sync_hi = vsw[9:8];
        h_front = hfp[7:0]; h_back = hbp[7:0];
        v_front = vfp[7:0]; v_back = vbp[7:0];
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        run_cycles("R1 reset idle", 4);
        rst_n = 1'b1;
        run_cycles("R1 idle after reset", 3);
    endtask

    task automatic t_basic();
        set_cfg(16, 4, 2, 1, 3, 2, 1, 1);
        enable = 1'b1;
        run_cycles("R2/R3/R4/R10/R11 basic frame", 2 * 161 + 10);
    endtask

    task automatic t_polarity();
        de_low = 1'b1; hs_low = 1'b0; vs_low = 1'b0;
        run_cycles("R9 inverted polarity", 120);
        de_low = 1'b0; hs_low = 1'b1; vs_low = 1'b1;
        run_cycles("R9 restored polarity", 20);
    endtask

    task automatic t_midframe_change();
        set_cfg(24, 3, 3, 2, 2, 4, 2, 1);
        run_cycles("R8 frame-boundary capture", 420);
    endtask

    task automatic t_disable_restart();
        enable = 1'b0;
        run_cycles("R1 disable mid-frame", 6);
        enable = 1'b1;
        run_cycles("R2 restart after re-enable", 220);
    endtask

    task automatic t_zero_widths();
        enable = 1'b0;
        run_cycles("R1 idle between scenarios", 2);
        set_cfg(260, 2, 0, 0, 0, 0, 0, 0);
        enable = 1'b1;
        run_cycles("R5/R6/R11 zero widths and saturating last bar", 1700);
    endtask

    task automatic t_zero_active();
        enable = 1'b0;
        run_cycles("R1 idle between scenarios", 2);
        set_cfg(0, 0, 1, 1, 1, 1, 1, 1);
        enable = 1'b1;
        run_cycles("R7 zero active size", 80);
    endtask

    task automatic t_high_fields();
        enable = 1'b0;
        run_cycles("R1 idle between scenarios", 2);
        set_cfg(8, 257, 1, 1, 0, 0, 0, 0);
        enable = 1'b1;
        run_cycles("R5 vertical high field", 2700);
        enable = 1'b0;
        run_cycles("R1 idle between scenarios", 2);
        set_cfg(8, 1, 300, 1, 0, 0, 0, 0);
        enable = 1'b1;
        run_cycles("R5 sync high field", 700);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_polarity();
        t_midframe_change();
        t_disable_restart();
        t_zero_widths();
        t_zero_active();
        t_high_fields();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule